// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer with Deferred Termination

This block is one DMA channel working in dual-address fashion. Each data unit is fetched by a read on the bus at the source address and then stored by a write of the same data at the destination address. The channel runs in one of two modes. In repeat mode every accepted request moves one unit. In block mode one accepted request moves a whole block of units back to back. A unit counter tracks progress through the programmed size and reloads itself when the size is used up.

Either address may be confined to an aligned window of 2^n bytes. Inside the window the upper address bits stay fixed and the low bits wrap. The channel ends a transfer for three reasons: a size-end event, a window wrap, or software clearing the enable bit. It never stops in the middle of work it has already committed to. A read is always followed by its write, a block is always finished, and a request that has been accepted is always served. When the channel stops on an interrupt cause, it clears its enable bit and sets a sticky end flag. The cause bits are held and drive the interrupt line.

Software programs the channel through a small word-addressed register port. Requests come in on a single level input that is sampled while the channel is idle. The bus side is a valid/ready handshake, and read data is returned in the cycle ready is high.

Top module: `dma_chan_seq`

## Requirements
- R1: Each data unit is one read at the source address followed by one write at the destination address, and the write carries the data returned by that read.
- R2: Once bus_valid is raised it stays high, with bus_addr, bus_we and bus_wdata unchanged, until the cycle in which bus_ready is high.
- R3: In repeat mode (control bit 2 clear) each request accepted while the enable bit (control bit 0) is set moves exactly one unit. Both addresses then advance by DW/8 bytes, and the unit counter reloads from the size register (offset 3, where 0 acts as 1) after that many units.
- R4: In block mode (control bit 2 set) one accepted request moves size units back to back with no further request.
- R5: With the size-end enable (control bit 3) set, a request that arrives after a repeat unit or block has completed is not served. Instead the enable bit clears, the end flag (control bit 1) sets, and cause bit 16 sets.
- R6: With a window enabled (source control bit 4, destination control bit 6, size 2^n bytes with n in control bits 12:8), an address advance keeps the upper bits and wraps the low n bits. With its overflow enable clear, a wrap does not stop the channel.
- R7: With an overflow enable set (source control bit 5, destination control bit 7), a wrap stops the channel after the write of the unit in which it happened. A wrap on the read is still followed by its write. The stop clears enable, sets the end flag and sets cause bit 17 (source) or 18 (destination).
- R8: In block mode a window overflow partway through a block stops the channel only after the rest of that block has been moved.
- R9: The end flag and cause bits stay set until a control write with bit 1 set clears them. irq is high exactly while an enabled cause is pending. Setting enable again resumes from the current addresses and count.
- R10: When software clears the enable bit, the unit already accepted (repeat) or the block in progress (block) completes, no further request is accepted, and the end flag is not set.
- R11: After reset the bus is idle, irq is low and the control register reads zero.
- R12: Register offsets are 0 control, 1 source address, 2 destination address and 3 size. The address registers read back the live addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| dreq | input | 1 | Transfer request, sampled while idle |
| bus_valid | output | 1 | Bus transaction valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Transaction accepted this cycle |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| irq | output | 1 | Interrupt, OR of enabled pending causes |

## Verification
The bench builds the block with its default widths: 32-bit addresses and data, which gives a 4-byte step, and a 16-bit count. Small sizes of one to eight units and windows of 8 to 32 bytes are enough to reach every corner. These include a wrap on the very first read of a block, a wrap on the final destination write, and a size-end request arriving right after a block. Random ready stalls stretch each transaction, so software clears and window overflows land in the middle of a unit or block rather than at its edges.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  localparam int CAUSE_W = 3;
  localparam int C_SIZE  = 0;
  localparam int C_SRC   = 1;
  localparam int C_DST   = 2;

  // register offsets
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SRC  = 2'd1;
  localparam logic [1:0] RA_DST  = 2'd2;
  localparam logic [1:0] RA_SIZE = 2'd3;

  typedef struct packed {
    logic [4:0] win_log2;
    logic       dst_ie;
    logic       dst_win;
    logic       src_ie;
    logic       src_win;
    logic       size_ie;
    logic       blk;
  } chan_cfg_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int RW = 32,
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [RW-1:0]      wdata,
  output logic [RW-1:0]      rdata,
  input  logic [RW-1:0]      src_cur,
  input  logic [RW-1:0]      dst_cur,
  input  logic               stop_evt,
  input  logic [CAUSE_W-1:0] stop_cause,
  output chan_cfg_t          cfg,
  output logic               en,
  output logic               flag,
  output logic [CAUSE_W-1:0] cause,
  output logic [CW-1:0]      size_q,
  output logic [1:0]         ld_addr,
  output logic               ld_cnt,
  output logic               irq
);
  localparam int B_EN    = 0;
  localparam int B_FLAG  = 1;
  localparam int B_BLK   = 2;
  localparam int B_SIE   = 3;
  localparam int B_SWIN  = 4;
  localparam int B_SIE2  = 5;
  localparam int B_DWIN  = 6;
  localparam int B_DIE   = 7;
  localparam int B_WIN_L = 8;
  localparam int B_CAU_L = 16;

  logic wr_ctrl;
  assign wr_ctrl    = we && (addr == RA_CTRL);
  assign ld_addr[0] = we && (addr == RA_SRC);
  assign ld_addr[1] = we && (addr == RA_DST);
  assign ld_cnt     = we && (addr == RA_SIZE);

  wire unused_hi = &{1'b0, wdata[RW-1:B_WIN_L+5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      en     <= 1'b0;
      flag   <= 1'b0;
      cause  <= '0;
      size_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.blk      <= wdata[B_BLK];
        cfg.size_ie  <= wdata[B_SIE];
        cfg.src_win  <= wdata[B_SWIN];
        cfg.src_ie   <= wdata[B_SIE2];
        cfg.dst_win  <= wdata[B_DWIN];
        cfg.dst_ie   <= wdata[B_DIE];
        cfg.win_log2 <= wdata[B_WIN_L+:5];
      end
      if (ld_cnt) size_q <= wdata[CW-1:0];
      // a stop event outranks a simultaneous software write
      if (stop_evt) begin
        en    <= 1'b0;
        flag  <= 1'b1;
        cause <= cause | stop_cause;
      end else begin
        if (wr_ctrl) en <= wdata[B_EN];
        if (wr_ctrl && wdata[B_FLAG]) begin
          flag  <= 1'b0;
          cause <= '0;
        end
      end
    end
  end

  assign irq = |(cause & {cfg.dst_ie, cfg.src_ie, cfg.size_ie});

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_CTRL: begin
        rdata[B_EN]              = en;
        rdata[B_FLAG]            = flag;
        rdata[B_BLK]             = cfg.blk;
        rdata[B_SIE]             = cfg.size_ie;
        rdata[B_SWIN]            = cfg.src_win;
        rdata[B_SIE2]            = cfg.src_ie;
        rdata[B_DWIN]            = cfg.dst_win;
        rdata[B_DIE]             = cfg.dst_ie;
        rdata[B_WIN_L+:5]        = cfg.win_log2;
        rdata[B_CAU_L+:CAUSE_W]  = cause;
      end
      RA_SRC:  rdata = src_cur;
      RA_DST:  rdata = dst_cur;
      default: rdata[CW-1:0] = size_q;
    endcase
  end
endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          adv,
  input  logic          win_en,
  input  logic [4:0]    win_log2,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  // returns {window carry, next address}
  function automatic logic [AW:0] win_step(input logic [AW-1:0] a,
                                           input logic [4:0]    n,
                                           input logic          wen);
    logic [AW-1:0] mask, low, sum;
    mask = wen ? ((AW'(1) << n) - AW'(1)) : '1;
    low  = a & mask;
    sum  = low + AW'(STEP);
    return {wen && (sum > mask), (a & ~mask) | (sum & mask)};
  endfunction

  logic [AW:0] nxt;
  assign nxt  = win_step(addr, win_log2, win_en);
  assign wrap = nxt[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (ld)  addr <= ld_val;
    else if (adv) addr <= nxt[AW-1:0];
  end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_cfg_t          cfg,
  input  logic               en,
  input  logic               ld_cnt,
  input  logic [CW-1:0]      ld_val,
  input  logic [CW-1:0]      size_q,
  input  logic               dreq,
  input  logic               bus_ready,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               src_wrap,
  input  logic               dst_wrap,
  output seq_st_e            st,
  output logic [DW-1:0]      rd_data,
  output logic               src_adv,
  output logic               dst_adv,
  output logic               stop_evt,
  output logic [CAUSE_W-1:0] stop_cause,
  output logic               unit_last
);
  logic [CW-1:0] cnt;
  logic          size_done;
  logic [1:0]    ovf_q;       // [0] source, [1] destination pending stop
  logic          rd_hs, wr_hs, try_acc, size_stop, start, seg_end, ovf_stop;
  logic          src_hit, dst_hit;
  logic [1:0]    ovf_all;

  assign rd_hs     = (st == ST_RD) && bus_ready;
  assign wr_hs     = (st == ST_WR) && bus_ready;
  assign unit_last = (cnt <= CW'(1));
  assign try_acc   = (st == ST_IDLE) && en && dreq;
  assign size_stop = try_acc && size_done && cfg.size_ie;
  assign start     = try_acc && !size_stop;
  assign src_hit   = rd_hs && src_wrap && cfg.src_ie;
  assign dst_hit   = wr_hs && dst_wrap && cfg.dst_ie;
  assign ovf_all   = {ovf_q[1] | dst_hit, ovf_q[0]};
  assign seg_end   = wr_hs && (!cfg.blk || unit_last);
  assign ovf_stop  = seg_end && (|ovf_all);
  assign stop_evt  = size_stop || ovf_stop;
  assign src_adv   = rd_hs;
  assign dst_adv   = wr_hs;

  always_comb begin
    stop_cause = '0;
    stop_cause[C_SIZE] = size_stop;
    stop_cause[C_SRC]  = ovf_stop && ovf_all[0];
    stop_cause[C_DST]  = ovf_stop && ovf_all[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      size_done <= 1'b0;
      ovf_q     <= '0;
      rd_data   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) st <= ST_RD;
        ST_RD:   if (rd_hs) st <= ST_WR;
        ST_WR:   if (wr_hs) st <= (cfg.blk && !unit_last) ? ST_RD : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (rd_hs) rd_data <= bus_rdata;

      if (ld_cnt)     cnt <= ld_val;
      else if (wr_hs) cnt <= unit_last ? size_q : cnt - CW'(1);

      if (ld_cnt || start || size_stop) size_done <= 1'b0;
      else if (wr_hs && unit_last)      size_done <= 1'b1;

      if (ovf_stop) ovf_q <= '0;
      else begin
        if (src_hit) ovf_q[0] <= 1'b1;
        if (dst_hit) ovf_q[1] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          dreq,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int STEP = DW / 8;

  chan_cfg_t          cfg_q;
  logic               ctl_en, ctl_flag, ld_cnt, stop_evt, unit_last;
  logic [CAUSE_W-1:0] cause, stop_cause;
  logic [CW-1:0]      size_q;
  logic [1:0]         ld_addr, ch_adv, ch_wrap, ch_win;
  logic [AW-1:0]      ch_addr [2];
  seq_st_e            st;
  logic [DW-1:0]      rd_data;
  logic               cfg_blk, seq_idle;

  assign ch_win   = {cfg_q.dst_win, cfg_q.src_win};
  assign cfg_blk  = cfg_q.blk;
  assign seq_idle = (st == ST_IDLE);

  dma_chan_regs #(.RW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .src_cur(ch_addr[0]), .dst_cur(ch_addr[1]),
    .stop_evt(stop_evt), .stop_cause(stop_cause), .cfg(cfg_q), .en(ctl_en),
    .flag(ctl_flag), .cause(cause), .size_q(size_q), .ld_addr(ld_addr),
    .ld_cnt(ld_cnt), .irq(irq)
  );

  // index 0 = source pointer, index 1 = destination pointer
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    dma_chan_addr #(.AW(AW), .STEP(STEP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld(ld_addr[g]), .ld_val(reg_wdata),
      .adv(ch_adv[g]), .win_en(ch_win[g]), .win_log2(cfg_q.win_log2),
      .addr(ch_addr[g]), .wrap(ch_wrap[g])
    );
  end

  dma_chan_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .en(ctl_en), .ld_cnt(ld_cnt),
    .ld_val(reg_wdata[CW-1:0]), .size_q(size_q), .dreq(dreq),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .src_wrap(ch_wrap[0]),
    .dst_wrap(ch_wrap[1]), .st(st), .rd_data(rd_data), .src_adv(ch_adv[0]),
    .dst_adv(ch_adv[1]), .stop_evt(stop_evt), .stop_cause(stop_cause),
    .unit_last(unit_last)
  );

  assign bus_valid = (st != ST_IDLE);
  assign bus_we    = (st == ST_WR);
  assign bus_addr  = (st == ST_WR) ? ch_addr[1] : ch_addr[0];
  assign bus_wdata = rd_data;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_we,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          en,
  input logic          flag,
  input logic          irq,
  input logic          stop_evt,
  input logic          blk,
  input logic          seq_idle,
  input logic          unit_last
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_wr_follows_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_we && bus_ready |=> bus_valid && bus_we);

  p_stop_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !en && flag);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_block_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && blk && !seq_idle |-> unit_last && bus_we && bus_ready);

  p_disabled_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && !en |=> seq_idle);
endmodule

bind dma_chan_seq dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .en(ctl_en), .flag(ctl_flag), .irq(irq), .stop_evt(stop_evt),
  .blk(cfg_blk), .seq_idle(seq_idle), .unit_last(unit_last)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0;
  logic        bus_valid, bus_we, irq;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0, n_err = 0, n_log = 0, rp = 0, rdy_pct = 100, cyc = 0;
  logic        lg_we   [1024];
  logic [31:0] lg_addr [1024];
  logic [31:0] lg_data [1024];
  logic [31:0] es, ed;
  bit          b_sw, b_dw;
  int          b_n;

  dma_chan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] a, input bit win, input int n);
    logic [31:0] sz;
    if (!win) return a + 32'd4;
    sz = 32'd1 << n;
    return a - (a % sz) + (((a % sz) + 32'd4) % sz);
  endfunction

  function automatic logic [31:0] ctl(input bit en, input bit blk, input bit sie,
      input bit sw, input bit swie, input bit dw, input bit dwie, input int n);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[1] = 1'b1; v[2] = blk; v[3] = sie;
    v[4] = sw; v[5] = swie; v[6] = dw; v[7] = dwie; v[12:8] = n[4:0];
    return v;
  endfunction

  // bus slave and transaction log
  always @(negedge clk) begin
    cyc = cyc + 1;
    bus_ready = ($urandom_range(0, 99) < rdy_pct);
    bus_rdata = mem_val(bus_addr);
    if (rst_n && bus_valid && bus_ready && n_log < 1024) begin
      lg_we[n_log]   = bus_we;
      lg_addr[n_log] = bus_addr;
      lg_data[n_log] = bus_we ? bus_wdata : bus_rdata;
      n_log = n_log + 1;
    end
  end

  initial begin
    wait (cyc > 150000);
    n_err = n_err + 1;
    $display("FAIL R11 watchdog expired act=%0d exp=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic req_pulse(input int gap);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int size,
      input logic [31:0] cfg, input int pct);
    wr_reg(2'd0, cfg & ~32'h1);
    wr_reg(2'd1, s);
    wr_reg(2'd2, d);
    wr_reg(2'd3, size);
    wr_reg(2'd0, cfg);
    rdy_pct = pct; es = s; ed = d;
    b_sw = cfg[4]; b_dw = cfg[6]; b_n = int'(cfg[12:8]);
    rp = n_log;
  endtask

  // compare the next k logged units with the bench's own address walk
  task automatic check_units(input string tag, input int k);
    for (int i = 0; i < k; i++) begin
      check({tag, " read dir"},   {31'd0, lg_we[rp]},     32'd0);
      check({tag, " read addr"},  lg_addr[rp],            es);
      check({tag, " write dir"},  {31'd0, lg_we[rp+1]},   32'd1);
      check({tag, " write addr"}, lg_addr[rp+1],          ed);
      check({tag, " write data"}, lg_data[rp+1],          mem_val(es));
      rp = rp + 2;
      es = nxt(es, b_sw, b_n);
      ed = nxt(ed, b_dw, b_n);
    end
    check({tag, " txn count"}, n_log, rp);
  endtask

  logic [31:0] rv, cfgw;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 bus_valid", {31'd0, bus_valid}, 32'd0);
    check("R11 irq", {31'd0, irq}, 32'd0);
    rd_reg(2'd0, rv);
    check("R11 ctrl", rv, 32'd0);

    // R1 R3 repeat mode, size 3, four requests (fourth after reload)
    setup(32'h1000, 32'h2000, 3, ctl(1,0,0,0,0,0,0,0), 50);
    for (int i = 0; i < 4; i++) begin
      req_pulse(30);
      check_units("R1 R3 repeat", 1);
    end
    rd_reg(2'd1, rv);
    check("R12 src readback", rv, es);
    rd_reg(2'd2, rv);
    check("R12 dst readback", rv, ed);

    // R5 R9 size-end stop in repeat mode, sticky flag, resume
    setup(32'h3000, 32'h4000, 2, ctl(1,0,1,0,0,0,0,0), 60);
    req_pulse(30); req_pulse(30);
    check_units("R5 first repeat unit", 2);
    req_pulse(30);
    check("R5 request not served", n_log, rp);
    rd_reg(2'd0, rv);
    check("R5 en cleared", {31'd0, rv[0]}, 32'd0);
    check("R5 flag set", {31'd0, rv[1]}, 32'd1);
    check("R5 size cause", {29'd0, rv[18:16]}, 32'd1);
    check("R9 irq high", {31'd0, irq}, 32'd1);
    repeat (10) @(negedge clk);
    check("R9 irq sticky", {31'd0, irq}, 32'd1);
    wr_reg(2'd0, ctl(1,0,1,0,0,0,0,0));
    check("R9 irq cleared", {31'd0, irq}, 32'd0);
    rd_reg(2'd0, rv);
    check("R9 flag cleared", {31'd0, rv[1]}, 32'd0);
    req_pulse(30);
    check_units("R9 resume", 1);

    // R4 block mode, then R5 size-end on next request
    setup(32'h5000, 32'h6000, 4, ctl(1,1,1,0,0,0,0,0), 50);
    req_pulse(80);
    check_units("R4 block", 4);
    req_pulse(30);
    check("R5 block next req", n_log, rp);
    rd_reg(2'd0, rv);
    check("R5 block flag/en", {30'd0, rv[1:0]}, 32'd2);

    // R7 source wrap on the read still performs the write
    setup(32'h7008, 32'h8000, 8, ctl(1,0,0,1,1,0,0,4), 50);
    req_pulse(30); req_pulse(30);
    check_units("R7 src wrap", 2);
    rd_reg(2'd0, rv);
    check("R7 src stop en/flag", {30'd0, rv[1:0]}, 32'd2);
    check("R7 src cause", {29'd0, rv[18:16]}, 32'd2);
    check("R7 irq", {31'd0, irq}, 32'd1);
    rd_reg(2'd1, rv);
    check("R6 src wrapped addr", rv, 32'h7000);
    req_pulse(30);
    check("R7 stopped", n_log, rp);

    // R8 overflow mid-block finishes the block
    setup(32'h9004, 32'hA000, 4, ctl(1,1,0,1,1,0,0,3), 40);
    req_pulse(120);
    check_units("R8 block wrap", 4);
    rd_reg(2'd0, rv);
    check("R8 stop after block", {30'd0, rv[1:0]}, 32'd2);
    check("R8 src cause", {29'd0, rv[18:16]}, 32'd2);

    // R6 destination window without overflow enable: silent wrap
    setup(32'hB000, 32'hC018, 16, ctl(1,0,0,0,0,1,0,5), 70);
    for (int i = 0; i < 10; i++) begin
      req_pulse(25);
      check_units("R6 dst wrap", 1);
    end
    rd_reg(2'd0, rv);
    check("R6 no stop", {30'd0, rv[1:0]}, 32'd1);

    // R7 destination wrap on the last write
    setup(32'hD100, 32'hD00C, 8, ctl(1,0,0,0,0,1,1,4), 50);
    req_pulse(30);
    check_units("R7 dst wrap", 1);
    rd_reg(2'd0, rv);
    check("R7 dst cause", {29'd0, rv[18:16]}, 32'd4);

    // R10 software clear during a block
    cfgw = ctl(1,1,0,0,0,0,0,0);
    setup(32'hE000, 32'hE800, 6, cfgw, 50);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (2) @(negedge clk);
    wr_reg(2'd0, cfgw & ~32'h3);
    repeat (100) @(negedge clk);
    check_units("R10 block finishes", 6);
    rd_reg(2'd0, rv);
    check("R10 no flag", {30'd0, rv[1:0]}, 32'd0);
    req_pulse(30);
    check("R10 no new block", n_log, rp);

    // R10 software clear in repeat mode while the unit is on the bus
    cfgw = ctl(1,0,0,0,0,0,0,0);
    setup(32'hF000, 32'hF400, 4, cfgw, 25);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    wr_reg(2'd0, cfgw & ~32'h3);
    repeat (60) @(negedge clk);
    check_units("R10 unit finishes", 1);
    req_pulse(30);
    check("R10 no new unit", n_log, rp);

    // random repeat traffic, R1 R3 R6
    setup({16'h2, 12'($urandom_range(0, 255)), 4'h0}, {16'h3, 12'($urandom_range(0, 255)), 4'h4},
          $urandom_range(1, 5), ctl(1,0,0,0,0,1,0,$urandom_range(3, 6)), 60);
    for (int i = 0; i < 40; i++) begin
      rdy_pct = $urandom_range(30, 100);
      req_pulse($urandom_range(20, 40));
      check_units("R3 random repeat", 1);
    end

    // random block traffic, R4
    for (int i = 0; i < 10; i++) begin
      int sz;
      sz = $urandom_range(1, 4);
      setup({16'h4, 12'($urandom_range(0, 255)), 4'h8}, {16'h5, 12'($urandom_range(0, 255)), 4'h0},
            sz, ctl(1,1,0,0,0,0,0,0), $urandom_range(30, 100));
      req_pulse(120);
      check_units("R4 random block", sz);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule